// File: doc/BRIEF.md
# Stepwise Iterative Integer Divider

This block divides an unsigned dividend, which arrives in two halves, by an unsigned divisor. An external sequencer splits the division into separate commands. A start command takes the upper half of the dividend together with the divisor. It forms a first partial quotient and remainder over that half and keeps the divisor for later. Each step command then feeds in bits of the lower half of the dividend, a few at a time. The sequencer gives each step the number of lower-half bits that are still unused. The block returns the reduced count and a zero flag, so the sequencer knows whether it has to issue another step.

The quotient, remainder and divisor registers keep their values between commands. Two read commands place the current quotient or the current remainder on the result bus and change nothing else. The arithmetic is restoring division, one dividend bit per clock. A single step handles no more than `STEP_BITS` bits. A start command with a zero divisor changes no arithmetic state and sets a sticky error flag instead.

Top module: `stepdiv`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `result_o`, `cnt_o`, `ezf_o` and `err_o` are all zero, and the quotient and remainder registers read back as zero.
- R2: A start command (`cmd_i` = 2'b00) with a non-zero `opb_i` latches `opb_i` as the divisor. It leaves quotient = `opa_i` / `opb_i` and remainder = `opa_i` mod `opb_i`, and `busy_o` stays high for exactly DW cycles.
- R3: A step command (`cmd_i` = 2'b01) with count c = `cnt_i` consumes n = min(c, STEP_BITS) bits of `opa_i`. It takes them from bit index c-1 downward. Each bit is shifted into the remainder, the divisor is subtracted when that fits, and one quotient bit is appended per consumed bit.
- R4: After a step, `cnt_o` equals `cnt_i` minus the number of bits consumed. Only step commands change `cnt_o`.
- R5: After a step, `ezf_o` is 1 exactly when no unused lower-half bits remain (`cnt_o` = 0). Only step commands change `ezf_o`.
- R6: A step with `cnt_i` = 0 leaves quotient and remainder unchanged. It sets `cnt_o` = 0 and `ezf_o` = 1, and raises `done_o` in the cycle after acceptance without asserting `busy_o`.
- R7: A read command returns the quotient (`cmd_i` = 2'b10) or the remainder (`cmd_i` = 2'b11) on `result_o`, with `done_o` in the cycle after acceptance. Repeated reads return the same value.
- R8: A start command with `opb_i` = 0 sets `err_o`, which stays high until reset. Quotient, remainder and the latched divisor keep their earlier values, and `done_o` follows in the next cycle.
- R9: A request is accepted only while `busy_o` is low, and a request made while busy has no effect. Completion of a command is marked by `done_o`, which is never high together with `busy_o`. A step that consumes n > 0 bits keeps `busy_o` high for exactly n cycles.
- R10: The quotient register is DW bits wide. Quotient bits shifted beyond the top are discarded, so the quotient is kept modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command request, accepted while not busy |
| cmd_i | input | 2 | 00 start, 01 step, 10 read quotient, 11 read remainder |
| opa_i | input | DW | Upper dividend half (start) or lower dividend half (step) |
| opb_i | input | DW | Divisor (start) |
| cnt_i | input | CW | Unused lower-half bit count (step); values above DW act as DW |
| busy_o | output | 1 | Bit-serial iteration in progress |
| done_o | output | 1 | Command completed |
| result_o | output | DW | Quotient or remainder from the last read |
| cnt_o | output | CW | Remaining unused bit count after the last step |
| ezf_o | output | 1 | No unused lower-half bits remain after the last step |
| err_o | output | 1 | Sticky zero-divisor flag |

## Verification
The hardest case to reach is a request that arrives while a start or step is still iterating. The sequencer normally waits for `done_o`, so such a request only occurs when the stimulus deliberately breaks the handshake. The bench does this on purpose: it raises a step request one cycle into a start. It then checks that the iteration length, `cnt_o` and the resulting quotient and remainder are unaffected. A second hard case is a zero-divisor start that arrives after a valid divisor has been latched. The bench places one between two steps of a live division and continues that division afterwards, which shows that the old divisor and partial results survived.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'b00,
    CMD_STEP  = 2'b01,
    CMD_RDQ   = 2'b10,
    CMD_RDR   = 2'b11
  } cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/stepdiv_rcell.sv
// One restoring-division bit: shift in, trial subtract, keep or restore.
module stepdiv_rcell #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rem_i,
  input  logic          bit_i,
  input  logic [DW-1:0] dvs_i,
  output logic [DW-1:0] rem_o,
  output logic          qbit_o
);
  logic [DW:0] shifted;
  logic [DW:0] trial;

  always_comb begin
    shifted = {rem_i, bit_i};
    trial   = shifted - {1'b0, dvs_i};
    qbit_o  = (shifted >= {1'b0, dvs_i});
    rem_o   = qbit_o ? trial[DW-1:0] : shifted[DW-1:0];
  end
endmodule

// File: rtl/stepdiv_ctrl.sv
module stepdiv_ctrl
  import stepdiv_pkg::*;
#(
  parameter int DW        = 8,
  parameter int STEP_BITS = 4,
  parameter int CW        = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  cmd_e          cmd_i,
  input  logic          div_zero_i,
  input  logic [CW-1:0] cnt_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          run_o,
  output logic [CW-1:0] idx_o,
  output logic          ld_start_o,
  output logic          ld_step_o,
  output logic          rd_q_o,
  output logic          rd_r_o,
  output logic          upd_cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          err_set_o
);
  localparam logic [CW-1:0] DW_C = CW'(DW);
  localparam logic [CW-1:0] ST_C = CW'(STEP_BITS);

  state_e        state_q;
  logic [CW-1:0] left_q;
  logic [CW-1:0] idx_q;
  logic          done_q;
  logic          accept;
  logic [CW-1:0] eff_cnt;
  logic [CW-1:0] take;

  assign accept  = req_i && (state_q == ST_IDLE);
  assign eff_cnt = (cnt_i > DW_C) ? DW_C : cnt_i;
  assign take    = (eff_cnt > ST_C) ? ST_C : eff_cnt;

  assign ld_start_o = accept && (cmd_i == CMD_START) && !div_zero_i;
  assign err_set_o  = accept && (cmd_i == CMD_START) && div_zero_i;
  assign ld_step_o  = accept && (cmd_i == CMD_STEP) && (take != '0);
  assign upd_cnt_o  = accept && (cmd_i == CMD_STEP);
  assign cnt_nxt_o  = eff_cnt - take;
  assign rd_q_o     = accept && (cmd_i == CMD_RDQ);
  assign rd_r_o     = accept && (cmd_i == CMD_RDR);
  assign run_o      = (state_q == ST_RUN);
  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign idx_o      = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else if (state_q == ST_RUN) begin
      left_q <= left_q - 1'b1;
      idx_q  <= idx_q - 1'b1;
      if (left_q == CW'(1)) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end else begin
        done_q <= 1'b0;
      end
    end else if (accept) begin
      if (ld_start_o) begin
        state_q <= ST_RUN;
        left_q  <= DW_C;
        idx_q   <= DW_C - 1'b1;
        done_q  <= 1'b0;
      end else if (ld_step_o) begin
        state_q <= ST_RUN;
        left_q  <= take;
        idx_q   <= eff_cnt - 1'b1;
        done_q  <= 1'b0;
      end else begin
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stepdiv_core.sv
module stepdiv_core #(
  parameter int DW = 8,
  parameter int CW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic          run_i,
  input  logic [CW-1:0] idx_i,
  input  logic          ld_start_i,
  input  logic          ld_step_i,
  input  logic          rd_q_i,
  input  logic          rd_r_i,
  input  logic          upd_cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic          err_set_i,
  output logic [DW-1:0] result_o,
  output logic [CW-1:0] cnt_o,
  output logic          ezf_o,
  output logic          err_o
);
  logic [DW-1:0] quo_q, rem_q, dvs_q, src_q;
  logic [DW-1:0] result_q;
  logic [CW-1:0] cnt_q;
  logic          ezf_q, err_q;
  logic [DW-1:0] sel_mask;
  logic          in_bit;
  logic [DW-1:0] rem_nxt;
  logic          qbit;

  assign sel_mask = DW'(1) << idx_i;
  assign in_bit   = |(src_q & sel_mask);

  stepdiv_rcell #(.DW(DW)) i_rcell (
    .rem_i  (rem_q),
    .bit_i  (in_bit),
    .dvs_i  (dvs_q),
    .rem_o  (rem_nxt),
    .qbit_o (qbit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      src_q <= '0;
    end else if (ld_start_i) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= opb_i;
      src_q <= opa_i;
    end else if (ld_step_i) begin
      src_q <= opa_i;
    end else if (run_i) begin
      quo_q <= {quo_q[DW-2:0], qbit};
      rem_q <= rem_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      cnt_q    <= '0;
      ezf_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (rd_q_i) result_q <= quo_q;
      else if (rd_r_i) result_q <= rem_q;
      if (upd_cnt_i) begin
        cnt_q <= cnt_nxt_i;
        ezf_q <= (cnt_nxt_i == '0);
      end
      if (err_set_i) err_q <= 1'b1;
    end
  end

  assign result_o = result_q;
  assign cnt_o    = cnt_q;
  assign ezf_o    = ezf_q;
  assign err_o    = err_q;
endmodule

// File: rtl/stepdiv.sv
module stepdiv
  import stepdiv_pkg::*;
#(
  parameter int DW        = 8,
  parameter int STEP_BITS = 4,
  parameter int CW        = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    cmd_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [CW-1:0] cnt_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o,
  output logic [CW-1:0] cnt_o,
  output logic          ezf_o,
  output logic          err_o
);
  logic          run;
  logic [CW-1:0] idx;
  logic          ld_start, ld_step, rd_q, rd_r, upd_cnt, err_set;
  logic [CW-1:0] cnt_nxt;

  stepdiv_ctrl #(.DW(DW), .STEP_BITS(STEP_BITS), .CW(CW)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .cmd_i      (cmd_e'(cmd_i)),
    .div_zero_i (opb_i == '0),
    .cnt_i      (cnt_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .run_o      (run),
    .idx_o      (idx),
    .ld_start_o (ld_start),
    .ld_step_o  (ld_step),
    .rd_q_o     (rd_q),
    .rd_r_o     (rd_r),
    .upd_cnt_o  (upd_cnt),
    .cnt_nxt_o  (cnt_nxt),
    .err_set_o  (err_set)
  );

  stepdiv_core #(.DW(DW), .CW(CW)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .run_i      (run),
    .idx_i      (idx),
    .ld_start_i (ld_start),
    .ld_step_i  (ld_step),
    .rd_q_i     (rd_q),
    .rd_r_i     (rd_r),
    .upd_cnt_i  (upd_cnt),
    .cnt_nxt_i  (cnt_nxt),
    .err_set_i  (err_set),
    .result_o   (result_o),
    .cnt_o      (cnt_o),
    .ezf_o      (ezf_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/stepdiv_chk.sv
module stepdiv_chk #(
  parameter int DW = 8,
  parameter int CW = $clog2(DW + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [1:0]    cmd_i,
  input logic [DW-1:0] opa_i,
  input logic [DW-1:0] opb_i,
  input logic [CW-1:0] cnt_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] result_o,
  input logic [CW-1:0] cnt_o,
  input logic          ezf_o,
  input logic          err_o
);
  logic acc;
  assign acc = req_i && !busy_o;

  p_done_not_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_end_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(cnt_o) && $stable(ezf_o) && $stable(result_o)));

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_zero_div_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 2'b00 && opb_i == '0) |=> (err_o && done_o && !busy_o));

  p_read_fast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i[1]) |=> (done_o && !busy_o));

  p_cnt_shrinks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 2'b01) |=> (cnt_o <= $past(cnt_i)));

  p_cnt_only_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i != 2'b01) |=> ($stable(cnt_o) && $stable(ezf_o)));

  p_zero_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 2'b01 && cnt_i == '0) |=> (done_o && ezf_o && cnt_o == '0));
endmodule

bind stepdiv stepdiv_chk #(.DW(DW), .CW(CW)) i_stepdiv_chk (.*);

// File: tb/test_stepdiv.sv
`timescale 1ns/1ps
module test_stepdiv;
  localparam int DW = 8;
  localparam int SB = 4;
  localparam int CW = $clog2(DW + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [1:0]    cmd_i = '0;
  logic [DW-1:0] opa_i = '0;
  logic [DW-1:0] opb_i = '0;
  logic [CW-1:0] cnt_i = '0;
  logic          busy_o, done_o, ezf_o, err_o;
  logic [DW-1:0] result_o;
  logic [CW-1:0] cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int mq = 0, mr = 0, md = 0;
  int lat;

  stepdiv #(.DW(DW), .STEP_BITS(SB), .CW(CW)) i_stepdiv (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // drive at negedge, wait for done, lat = negedges waited after acceptance
  task automatic issue(input logic [1:0] c, input int a, input int b, input int n);
    cmd_i = c; opa_i = DW'(a); opb_i = DW'(b); cnt_i = CW'(n); req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic do_start(input int hi, input int d, input string tag);
    issue(2'b00, hi, d, 0);
    if (d != 0) begin
      md = d; mq = hi / d; mr = hi % d;
      chk(lat == DW, "R9 start busy length", lat, DW);
    end else begin
      chk(lat == 0, "R8 zero-divisor latency", lat, 0);
      chk(err_o == 1'b1, "R8 err set", err_o, 1);
    end
  endtask

  task automatic do_step(input int lo, input int c, input string tag);
    int n, bits, t;
    n = (c > SB) ? SB : c;
    bits = (lo >> (c - n)) & ((1 << n) - 1);
    t = (mr << n) | bits;
    mq = ((mq << n) + t / md) & ((1 << DW) - 1);
    mr = t % md;
    issue(2'b01, lo, 0, c);
    chk(lat == n, {tag, " R9 step busy length"}, lat, n);
    chk(int'(cnt_o) == c - n, "R4 remaining count", cnt_o, c - n);
    chk(ezf_o == (c - n == 0), "R5 zero flag", ezf_o, (c - n == 0));
  endtask

  task automatic rd(input bit rem, input string tag);
    int exp;
    exp = rem ? mr : mq;
    issue(rem ? 2'b11 : 2'b10, 0, 0, 0);
    chk(lat == 0, {tag, " R7 read latency"}, lat, 0);
    chk(int'(result_o) == exp, tag, result_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && err_o == 0 && ezf_o == 0, "R1 flags in reset",
        {busy_o, done_o, err_o, ezf_o}, 0);
    chk(result_o == 0 && cnt_o == 0, "R1 data in reset", result_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(1'b0, "R1 quotient after reset");
    rd(1'b1, "R1 remainder after reset");

    // full sweep of divisors, several dividends each
    for (int d = 1; d < 256; d++) begin
      for (int k = 0; k < 4; k++) begin
        int hi, lo;
        hi = (d * 37 + k * 91 + k * k * 13) & 255;
        lo = (d * 13 + k * 59 + 7) & 255;
        do_start(hi, d, "R2");
        rd(1'b0, "R2 quotient");
        rd(1'b1, "R2 remainder");
        if (k < 2) begin
          do_step(lo, 8, "R3");
          do_step(lo, 4, "R3");
        end else begin
          do_step(lo, 6, "R3");
          do_step(lo, 2, "R3");
        end
        rd(1'b0, "R3 quotient");
        rd(1'b1, "R3 remainder");
      end
    end
    chk(err_o == 0, "R8 no error without zero divisor", err_o, 0);

    // odd counts, zero-count step, repeated reads
    do_start(200, 7, "R2");
    do_step(8'hB5, 3, "R3");
    rd(1'b0, "R3 quotient odd count");
    rd(1'b1, "R3 remainder odd count");
    issue(2'b01, 8'hFF, 0, 0);
    chk(lat == 0, "R6 zero-count latency", lat, 0);
    chk(cnt_o == 0 && ezf_o == 1, "R6 count/flag", cnt_o, 0);
    rd(1'b0, "R6 quotient unchanged");
    rd(1'b1, "R6 remainder unchanged");
    rd(1'b1, "R7 repeated remainder");
    rd(1'b0, "R7 repeated quotient");
    rd(1'b0, "R7 second repeated quotient");

    // quotient overflow: divisor 1 and full 16-bit dividend
    do_start(255, 1, "R10");
    do_step(8'hA7, 8, "R10");
    do_step(8'hA7, 4, "R10");
    rd(1'b0, "R10 truncated quotient");
    chk(mq == 8'hA7, "R10 model quotient", mq, 8'hA7);
    rd(1'b1, "R10 remainder");

    // request while busy is ignored
    begin
      int prev_cnt;
      do_start(50, 9, "R2");
      do_step(8'h3C, 8, "R3");
      prev_cnt = cnt_o;
      cmd_i = 2'b00; opa_i = 8'd201; opb_i = 8'd11; req_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      cmd_i = 2'b01; opa_i = 8'hFF; cnt_i = CW'(5);
      @(posedge clk_i);
      @(negedge clk_i);
      req_i = 1'b0;
      lat = 1;
      while (!done_o && lat < 100) begin
        @(negedge clk_i);
        lat++;
      end
      md = 11; mq = 201 / 11; mr = 201 % 11;
      chk(lat == DW, "R9 busy length with stray request", lat, DW);
      chk(int'(cnt_o) == prev_cnt, "R9 stray step ignored", cnt_o, prev_cnt);
      rd(1'b0, "R9 quotient after stray request");
      rd(1'b1, "R9 remainder after stray request");
    end

    // zero divisor in the middle of a division
    do_start(173, 13, "R2");
    do_step(8'h9E, 8, "R3");
    do_start(99, 0, "R8");
    rd(1'b0, "R8 quotient kept");
    rd(1'b1, "R8 remainder kept");
    do_step(8'h9E, 4, "R8 old divisor");
    rd(1'b0, "R8 quotient with old divisor");
    rd(1'b1, "R8 remainder with old divisor");
    do_start(40, 3, "R2");
    chk(err_o == 1, "R8 err sticky", err_o, 1);

    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(err_o == 0, "R8 err cleared by reset", err_o, 0);
    chk(cnt_o == 0 && ezf_o == 0, "R1 count after reset", cnt_o, 0);

    finish_run();
  end
endmodule